// File: doc/BRIEF.md
# Vector Priority Interrupt Controller

This block tracks up to 256 interrupt vectors for one processor. Sources post a vector together with its trigger mode. The block keeps three bit arrays: one for pending requests, one for vectors in service, and one recording which requests were level triggered. It also keeps a task priority value and a spurious vector setting. The vector number sets the priority: a larger number is more urgent. Vectors fall into priority classes of sixteen, and the class is the upper nibble of the vector.

A processor priority is formed from the task priority and the most urgent in-service vector. The interrupt line is raised when a pending request belongs to a class above that priority. When the processor acknowledges, the block either moves the most urgent request into service and returns its vector, or returns the spurious vector if the task priority blocks the request. An end-of-interrupt retires the most urgent in-service vector. Software can read all three arrays, the task priority and the spurious setting one 32-bit word at a time.

A small acknowledge sequencer reports the outcome of each acknowledge. It has three states:
- `ST_IDLE`: no acknowledge was taken on the last edge.
- `ST_GRANT`: a request moved into service and its vector is presented.
- `ST_SPUR`: the spurious vector is presented.

From any state, an edge with `ack` high moves to `ST_GRANT` (grant transition) or to `ST_SPUR` (reject transition). An edge with `ack` low returns to `ST_IDLE` (release transition).

Top module: `vpic_top`

## Requirements
- R1: A set request (`set_en` high for one edge) sets the request bit of `set_vec`. It also writes that vector's trigger bit: `set_level` = 1 marks level and stores 1, and `set_level` = 0 marks edge and stores 0.
- R2: `rd_data` is combinational. `rd_sel` = 0 reads the request array, 1 the in-service array, and 2 the trigger array. For those three, `rd_word` = i returns vectors 32i..32i+31, with vector 32i+j at bit j. `rd_sel` = 3 returns the task priority in bits 7:0, the spurious register in bits 16:8, and zeros above.
- R3: `ppr` equals the task priority when no vector is in service, or when the task priority is at least the most urgent in-service vector. Otherwise `ppr` is that vector's class with the low nibble zero.
- R4: `intr` is high only when bit 8 of the spurious register (software enable) is set and a request is pending. In addition, when `ppr` is nonzero, the pending class must be strictly greater than `ppr[7:4]`.
- R5: An acknowledge that is not blocked moves the most urgent request bit into the in-service array. On the next cycle, `ack_valid` = 1, `ack_spurious` = 0, and `ack_vec` holds that vector.
- R6: An acknowledge while the task priority is nonzero and the most urgent request is at or below it changes no array. On the next cycle, `ack_valid` = 1, `ack_spurious` = 1, and `ack_vec` holds the spurious register's bits 7:0.
- R7: An acknowledge with no request pending is handled as spurious, as in R6.
- R8: An end-of-interrupt clears the most urgent in-service bit. When nothing is in service, it changes nothing.
- R9: A task priority write stores the 4-bit `tpr_val` in bits 7:4 of the task priority register, with bits 3:0 zero.
- R10: The spurious register holds the 9 bits written through `svr_wr`. It resets to 0x0FF, which leaves software enable off.
- R11: After reset, all arrays and the task priority are zero, and `intr`, `ack_valid` and `ppr` are 0.
- R12: If one edge carries a set, an acknowledge and an end-of-interrupt, the end-of-interrupt acts on the in-service state from before that edge. The acknowledge's in-service set then overrides the end-of-interrupt's clear, and a set request overrides the acknowledge's request clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_en | input | 1 | Post a vector request |
| set_vec | input | 8 | Vector to post |
| set_level | input | 1 | 1 = level, 0 = edge |
| ack | input | 1 | Processor acknowledge |
| eoi | input | 1 | End of interrupt |
| tpr_wr | input | 1 | Task priority write |
| tpr_val | input | 4 | Task priority class |
| svr_wr | input | 1 | Spurious register write |
| svr_val | input | 9 | Spurious register value (bit 8 = enable) |
| rd_sel | input | 2 | Read source select |
| rd_word | input | 3 | Word index within an array |
| rd_data | output | 32 | Read data |
| intr | output | 1 | Interrupt pending to processor |
| ack_valid | output | 1 | Acknowledge result present |
| ack_spurious | output | 1 | Result is the spurious vector |
| ack_vec | output | 8 | Returned vector |
| ppr | output | 8 | Processor priority |

## Verification
The bench steps through cases where the class comparison and the task priority test give different answers. In one case, a request sits in the same class as the task priority but above its value, so `intr` is low while an acknowledge still grants. A design that tested `intr` before granting would return the spurious vector there instead. Vectors 0 and 255 probe the word and bit mapping at both ends of the arrays. An end-of-interrupt with nothing in service and an acknowledge with nothing pending check that an empty priority encoder corrupts no state. Clearing the software enable must drop `intr` while requests remain pending.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_SPUR  = 2'd2
    } ack_state_e;

    localparam logic [1:0] RD_REQ  = 2'd0;
    localparam logic [1:0] RD_SVC  = 2'd1;
    localparam logic [1:0] RD_TRIG = 2'd2;
    localparam logic [1:0] RD_CTRL = 2'd3;
endpackage

// File: rtl/vpic_prio_enc.sv
module vpic_prio_enc #(
    parameter int W = 256
) (
    input  logic [W-1:0]         bits_in,
    output logic [$clog2(W)-1:0] top_idx,
    output logic                 any_set
);
    localparam int IW = $clog2(W);

    always_comb begin
        top_idx = '0;
        for (int i = 0; i < W; i++) begin
            if (bits_in[i]) top_idx = IW'(i);
        end
    end

    assign any_set = |bits_in;
endmodule

// File: rtl/vpic_prio_calc.sv
module vpic_prio_calc #(
    parameter int VW = 8
) (
    input  logic [VW-1:0] tpr,
    input  logic [VW-1:0] svc_top,
    input  logic          svc_any,
    input  logic [VW-1:0] req_top,
    input  logic          req_any,
    input  logic          sw_en,
    output logic [VW-1:0] ppr,
    output logic          intr,
    output logic          blocked
);
    always_comb begin
        if (!svc_any || tpr >= svc_top) ppr = tpr;
        else                            ppr = {svc_top[VW-1:4], 4'b0000};
    end

    assign intr    = sw_en && req_any &&
                     ((ppr == '0) || (req_top[VW-1:4] > ppr[VW-1:4]));
    assign blocked = !req_any || ((tpr != '0) && (req_top <= tpr));
endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
#(
    parameter int NVEC = 256,
    parameter int WORD = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            set_en,
    input  logic [$clog2(NVEC)-1:0]         set_vec,
    input  logic                            set_level,
    input  logic                            ack,
    input  logic                            eoi,
    input  logic                            tpr_wr,
    input  logic [$clog2(NVEC)-5:0]         tpr_val,
    input  logic                            svr_wr,
    input  logic [$clog2(NVEC):0]           svr_val,
    input  logic [1:0]                      rd_sel,
    input  logic [$clog2(NVEC/WORD)-1:0]    rd_word,
    output logic [WORD-1:0]                 rd_data,
    output logic                            intr,
    output logic                            ack_valid,
    output logic                            ack_spurious,
    output logic [$clog2(NVEC)-1:0]         ack_vec,
    output logic [$clog2(NVEC)-1:0]         ppr
);
    localparam int VW  = $clog2(NVEC);
    localparam int CLW = VW - 4;
    localparam int SVW = VW + 1;
    localparam logic [SVW-1:0] SVR_RST = {1'b0, {VW{1'b1}}};

    logic [NVEC-1:0] req_q, svc_q, trig_q;
    logic [NVEC-1:0] req_d, svc_d, trig_d;
    logic [VW-1:0]   tpr_q;
    logic [SVW-1:0]  svr_q;
    logic [VW-1:0]   req_top, svc_top, vec_q;
    logic            req_any, svc_any, blocked;
    ack_state_e      state_q, state_d;

    vpic_prio_enc #(.W(NVEC)) u_req_enc (
        .bits_in(req_q), .top_idx(req_top), .any_set(req_any));
    vpic_prio_enc #(.W(NVEC)) u_svc_enc (
        .bits_in(svc_q), .top_idx(svc_top), .any_set(svc_any));

    vpic_prio_calc #(.VW(VW)) u_calc (
        .tpr(tpr_q), .svc_top(svc_top), .svc_any(svc_any),
        .req_top(req_top), .req_any(req_any), .sw_en(svr_q[VW]),
        .ppr(ppr), .intr(intr), .blocked(blocked));

    // next array state: eoi, then ack, then set (later overrides earlier)
    always_comb begin
        req_d  = req_q;
        svc_d  = svc_q;
        trig_d = trig_q;
        if (eoi && svc_any) svc_d[svc_top] = 1'b0;
        if (ack && !blocked) begin
            req_d[req_top] = 1'b0;
            svc_d[req_top] = 1'b1;
        end
        if (set_en) begin
            req_d[set_vec]  = 1'b1;
            trig_d[set_vec] = set_level;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            svc_q  <= '0;
            trig_q <= '0;
            tpr_q  <= '0;
            svr_q  <= SVR_RST;
        end else begin
            req_q  <= req_d;
            svc_q  <= svc_d;
            trig_q <= trig_d;
            if (tpr_wr) tpr_q <= {tpr_val, 4'b0000};
            if (svr_wr) svr_q <= svr_val;
        end
    end

    // acknowledge sequencer: next state
    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_GRANT, ST_SPUR:
                if (ack) state_d = blocked ? ST_SPUR : ST_GRANT;
                else     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (ack) vec_q <= blocked ? svr_q[VW-1:0] : req_top;
        end
    end

    // outputs from state
    always_comb begin
        ack_vec = vec_q;
        unique case (state_q)
            ST_GRANT: begin ack_valid = 1'b1; ack_spurious = 1'b0; end
            ST_SPUR:  begin ack_valid = 1'b1; ack_spurious = 1'b1; end
            default:  begin ack_valid = 1'b0; ack_spurious = 1'b0; end
        endcase
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_sel)
            RD_REQ:  rd_data = req_q[rd_word*WORD +: WORD];
            RD_SVC:  rd_data = svc_q[rd_word*WORD +: WORD];
            RD_TRIG: rd_data = trig_q[rd_word*WORD +: WORD];
            default: begin
                rd_data[VW-1:0]       = tpr_q;
                rd_data[VW+SVW-1:VW]  = svr_q;
            end
        endcase
    end

    logic unused_clw;
    assign unused_clw = (CLW > 0);
endmodule

// File: rtl/vpic_chk.sv
module vpic_chk
    import vpic_pkg::*;
#(
    parameter int NVEC = 256,
    parameter int WORD = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    ack,
    input logic                    eoi,
    input logic                    tpr_wr,
    input logic [$clog2(NVEC)-5:0] tpr_val,
    input logic                    intr,
    input logic                    ack_valid,
    input logic                    ack_spurious,
    input logic [$clog2(NVEC)-1:0] ack_vec,
    input logic [$clog2(NVEC):0]   svr_q,
    input logic [$clog2(NVEC)-1:0] tpr_q,
    input logic [NVEC-1:0]         svc_q,
    input ack_state_e              state_q
);
    localparam int VW = $clog2(NVEC);

    // R4
    intr_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intr |-> svr_q[VW]);

    // R5
    ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(ack));

    // R5
    grant_in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GRANT) |-> svc_q[ack_vec]);

    // R6
    spur_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ack) && ack_spurious) |-> (ack_vec == $past(svr_q[VW-1:0])));

    // R8
    eoi_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !ack && (svc_q == '0)) |=> (svc_q == '0));

    // R9
    tpr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tpr_wr |=> (tpr_q == {$past(tpr_val), 4'b0000}));
endmodule

bind vpic_top vpic_chk #(.NVEC(NVEC), .WORD(WORD)) u_chk (
    .clk(clk), .rst_n(rst_n), .ack(ack), .eoi(eoi), .tpr_wr(tpr_wr),
    .tpr_val(tpr_val), .intr(intr), .ack_valid(ack_valid),
    .ack_spurious(ack_spurious), .ack_vec(ack_vec), .svr_q(svr_q),
    .tpr_q(tpr_q), .svc_q(svc_q), .state_q(state_q));

// File: tb/sim_vpic_top.sv
`timescale 1ns/1ps
module sim_vpic_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_en = 0, set_level = 0, ack = 0, eoi = 0;
    logic        tpr_wr = 0, svr_wr = 0;
    logic [7:0]  set_vec = 0;
    logic [3:0]  tpr_val = 0;
    logic [8:0]  svr_val = 0;
    logic [1:0]  rd_sel = 0;
    logic [2:0]  rd_word = 0;
    logic [31:0] rd_data;
    logic        intr, ack_valid, ack_spurious;
    logic [7:0]  ack_vec, ppr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    vpic_top u0 (.*);

    // op codes for the table
    localparam logic [2:0] OP_SETE = 3'd1, OP_SETL = 3'd2, OP_ACK = 3'd3,
                           OP_EOI = 3'd4, OP_TPR = 3'd5, OP_SVR = 3'd6;
    // {op, arg[8:0], exp_intr, exp_ppr, exp_spur, exp_vec}
    localparam int NSTEP = 23;
    localparam logic [29:0] STEPS [NSTEP] = '{
        {OP_SVR,  9'h1FF, 1'b0, 8'h00, 1'b0, 8'h00},
        {OP_SETE, 9'h045, 1'b1, 8'h00, 1'b0, 8'h00},
        {OP_SETL, 9'h092, 1'b1, 8'h00, 1'b0, 8'h00},
        {OP_ACK,  9'h000, 1'b0, 8'h90, 1'b0, 8'h92},
        {OP_SETE, 9'h0A3, 1'b1, 8'h90, 1'b0, 8'h00},
        {OP_ACK,  9'h000, 1'b0, 8'hA0, 1'b0, 8'hA3},
        {OP_EOI,  9'h000, 1'b0, 8'h90, 1'b0, 8'h00},
        {OP_EOI,  9'h000, 1'b1, 8'h00, 1'b0, 8'h00},
        {OP_TPR,  9'h005, 1'b0, 8'h50, 1'b0, 8'h00},
        {OP_ACK,  9'h000, 1'b0, 8'h50, 1'b1, 8'hFF},
        {OP_TPR,  9'h004, 1'b0, 8'h40, 1'b0, 8'h00},
        {OP_ACK,  9'h000, 1'b0, 8'h40, 1'b0, 8'h45},
        {OP_EOI,  9'h000, 1'b0, 8'h40, 1'b0, 8'h00},
        {OP_EOI,  9'h000, 1'b0, 8'h40, 1'b0, 8'h00},
        {OP_ACK,  9'h000, 1'b0, 8'h40, 1'b1, 8'hFF},
        {OP_SVR,  9'h0E7, 1'b0, 8'h40, 1'b0, 8'h00},
        {OP_SETE, 9'h0F0, 1'b0, 8'h40, 1'b0, 8'h00},
        {OP_SVR,  9'h1E7, 1'b1, 8'h40, 1'b0, 8'h00},
        {OP_TPR,  9'h00F, 1'b0, 8'hF0, 1'b0, 8'h00},
        {OP_ACK,  9'h000, 1'b0, 8'hF0, 1'b1, 8'hE7},
        {OP_TPR,  9'h000, 1'b1, 8'h00, 1'b0, 8'h00},
        {OP_ACK,  9'h000, 1'b0, 8'hF0, 1'b0, 8'hF0},
        {OP_EOI,  9'h000, 1'b0, 8'h00, 1'b0, 8'h00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] s, input logic [2:0] w, output logic [31:0] v);
        rd_sel = s; rd_word = w; #1; v = rd_data;
    endtask

    task automatic step(input logic [2:0] op, input logic [8:0] arg);
        @(negedge clk);
        case (op)
            OP_SETE: begin set_en = 1; set_vec = arg[7:0]; set_level = 0; end
            OP_SETL: begin set_en = 1; set_vec = arg[7:0]; set_level = 1; end
            OP_ACK:  ack = 1;
            OP_EOI:  eoi = 1;
            OP_TPR:  begin tpr_wr = 1; tpr_val = arg[3:0]; end
            OP_SVR:  begin svr_wr = 1; svr_val = arg; end
            default: ;
        endcase
        @(negedge clk);
        set_en = 0; ack = 0; eoi = 0; tpr_wr = 0; svr_wr = 0;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk("R11 intr", {31'b0, intr}, 0);
        chk("R11 ack_valid", {31'b0, ack_valid}, 0);
        chk("R11 ppr", {24'b0, ppr}, 0);
        for (int w = 0; w < 8; w++) begin
            rd(2'd0, 3'(w), v); chk("R11 req word", v, 0);
            rd(2'd1, 3'(w), v); chk("R11 svc word", v, 0);
        end
        // R10 reset value of spurious register, R2 control word layout
        rd(2'd3, 3'd0, v); chk("R10 R2 ctrl word after reset", v, 32'h0000FF00);

        // table walk: R3 R4 R5 R6 R7 R8 R9 R10
        for (int i = 0; i < NSTEP; i++) begin
            logic [29:0] e;
            e = STEPS[i];
            @(negedge clk);
            case (e[29:27])
                OP_SETE: begin set_en = 1; set_vec = e[25:18]; set_level = 0; end
                OP_SETL: begin set_en = 1; set_vec = e[25:18]; set_level = 1; end
                OP_ACK:  ack = 1;
                OP_EOI:  eoi = 1;
                OP_TPR:  begin tpr_wr = 1; tpr_val = e[21:18]; end
                OP_SVR:  begin svr_wr = 1; svr_val = e[26:18]; end
                default: ;
            endcase
            @(negedge clk);
            if (e[29:27] == OP_ACK) begin
                chk("R5 R6 R7 ack_valid", {31'b0, ack_valid}, 1);
                chk("R5 R6 R7 ack_spurious", {31'b0, ack_spurious}, {31'b0, e[8]});
                chk("R5 R6 R7 ack_vec", {24'b0, ack_vec}, {24'b0, e[7:0]});
            end
            chk("R4 intr", {31'b0, intr}, {31'b0, e[17]});
            chk("R3 ppr", {24'b0, ppr}, {24'b0, e[16:9]});
            set_en = 0; ack = 0; eoi = 0; tpr_wr = 0; svr_wr = 0;
        end
        // R6 blocked ack left request array unchanged; now all empty
        for (int w = 0; w < 8; w++) begin
            rd(2'd0, 3'(w), v); chk("R6 R8 req empty", v, 0);
            rd(2'd1, 3'(w), v); chk("R8 svc empty", v, 0);
        end
        rd(2'd3, 3'd0, v); chk("R9 R10 ctrl word", v, 32'h0001E700);

        // R1 R2 boundary vectors 0 and 255
        step(OP_SETL, 9'h000);
        step(OP_SETE, 9'h0FF);
        rd(2'd0, 3'd0, v); chk("R1 R2 req word0", v, 32'h00000001);
        rd(2'd0, 3'd7, v); chk("R1 R2 req word7", v, 32'h80000000);
        rd(2'd2, 3'd0, v); chk("R1 trig level", v, 32'h00000001);
        rd(2'd2, 3'd7, v); chk("R1 trig edge", v, 32'h00000000);
        step(OP_SETE, 9'h000);
        rd(2'd2, 3'd0, v); chk("R1 trig cleared by edge", v, 32'h00000000);
        step(OP_ACK, 0);
        rd(2'd1, 3'd7, v); chk("R5 svc word7", v, 32'h80000000);
        step(OP_ACK, 0);
        rd(2'd1, 3'd0, v); chk("R5 svc word0", v, 32'h00000001);
        chk("R3 ppr two in service", {24'b0, ppr}, 32'hF0);
        step(OP_EOI, 0);
        rd(2'd1, 3'd7, v); chk("R8 eoi highest first", v, 0);
        rd(2'd1, 3'd0, v); chk("R8 lower kept", v, 32'h00000001);

        // R12 set and ack of same vector on one edge: request stays
        step(OP_SETE, 9'h033);
        @(negedge clk);
        ack = 1; set_en = 1; set_vec = 8'h33; set_level = 0;
        @(negedge clk);
        ack = 0; set_en = 0;
        chk("R12 ack vec", {24'b0, ack_vec}, 32'h33);
        rd(2'd0, 3'd1, v); chk("R12 request kept", v, 32'h00080000);
        rd(2'd1, 3'd1, v); chk("R12 in service", v, 32'h00080000);

        // R4 enable off drops intr with request pending
        step(OP_EOI, 0); step(OP_EOI, 0);
        chk("R4 intr enabled", {31'b0, intr}, 1);
        step(OP_SVR, 9'h0FF);
        chk("R4 intr disabled", {31'b0, intr}, 0);

        done = 1;
        finish_run();
    end
endmodule